// File: doc/BRIEF.md
# Multiplexed-Bus Flash Host Controller

This block is the host side of a flash interface in which address and data share one bidirectional bus. An internal client asks for single-word reads and writes through a level request that is held until a one-cycle acknowledge. For each request the controller walks through a fixed series of phases:

- It selects the device and drives the address onto the shared bus.
- It pulses an active-low address-valid strobe and holds the address through the strobe's rising edge.
- For a read, it releases the bus and then lowers output enable.
- For a write, it lowers write enable and drives the data word.
- It finishes with a recovery gap and the acknowledge.

Between requests the device is deselected, which is its standby state. On demand the controller pulses the device's active-low hardware reset instead. Every phase length is a cycle count taken from configuration inputs. A count of zero acts as one.

The bus pins are split into an output word, an output-enable and an input word, so a pad ring can form the tri-state pad.

Top module: `muxFlashHost`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it rises, `fCeN`, `fOeN`, `fWeN`, `fAvdN` and `fRstN` are 1, `fAdqOe` is 0 and `reqAck` is 0.
- R2: A request is accepted at a clock edge in idle. Then `fCeN` goes to 0 and the address is driven on `fAdqOut` with `fAdqOe`=1, in three steps:
  - `setup` cycles with `fAvdN`=1.
  - `avdWidth` cycles with `fAvdN`=0.
  - One hold cycle with `fAvdN`=1, during which the address is still driven.
- R3: For a read (`reqWrite`=0), the hold cycle is followed by one turnaround cycle with the bus released and `fOeN`=1. Then come `access` cycles with `fOeN`=0 and the bus released. `fWeN` stays 1 for the whole read.
- R4: Read data is sampled from `fAdqIn` at the clock edge that ends the output-enable phase. It is held on `rspData` and is valid while `reqAck` is 1.
- R5: For a write (`reqWrite`=1), the hold cycle is followed by `access` cycles with `fWeN`=0, `fOeN`=1, `fCeN`=0, and `reqWdata` driven on the bus.
- R6: After the data phase come `recover` cycles in which every strobe is 1 and the bus is released. Then `reqAck` is 1 for exactly one cycle, and after that the block is idle.
- R7: In idle, `fCeN`=1 (standby), `fOeN`=`fWeN`=`fAvdN`=`fRstN`=1, and `fAdqOe`=0.
- R8: A `devRstReq` of 1 seen in idle gives `rstWidth` cycles of `fRstN`=0 with every other strobe at 1, the bus released, and no acknowledge. The reset pulse wins over a request presented at the same edge.
- R9: Requests and `devRstReq` are ignored while a cycle or a reset pulse is in progress. A request still held afterwards is accepted at the first idle edge. Exactly one acknowledge is given per completed cycle.
- R10: A configuration count of 0 gives the same timing as a count of 1.
- R11: `fOeN` is never 0 while the bus is driven or while `fAvdN` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low controller reset |
| reqValid | input | 1 | Request present; held until acknowledged |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | DATA_W | Word address |
| reqWdata | input | DATA_W | Write data |
| devRstReq | input | 1 | Ask for a device hardware-reset pulse |
| cfgSetup | input | CNT_W | Address setup cycles before the strobe |
| cfgAvdWidth | input | CNT_W | Address-valid low cycles |
| cfgAccess | input | CNT_W | Output-enable or write-enable low cycles |
| cfgRecover | input | CNT_W | Recovery cycles before acknowledge |
| cfgRstWidth | input | CNT_W | Device reset pulse cycles |
| reqAck | output | 1 | One-cycle completion pulse |
| rspData | output | DATA_W | Captured read data |
| fAdqOut | output | DATA_W | Shared bus output value |
| fAdqOe | output | 1 | Shared bus drive enable |
| fAdqIn | input | DATA_W | Shared bus input value |
| fCeN | output | 1 | Chip enable, active low |
| fOeN | output | 1 | Output enable, active low |
| fWeN | output | 1 | Write enable, active low |
| fAvdN | output | 1 | Address-valid strobe, active low |
| fRstN | output | 1 | Device hardware reset, active low |

## Verification
Each phase of the sequencer shows directly on the device pins, so a wrong state or a wrong count appears at the ports in the very cycle it occurs. That includes a phase that is too long, a phase that is skipped, or a wrong read/write branch. It shows as a mismatched strobe, drive enable or bus word. A capture made one cycle too early returns a poison word from the bench's device model. That word appears on `rspData` in the acknowledge cycle, a few cycles after the faulty sample. A lost or doubled acknowledge appears as a strobe mismatch at the next request, and again in the final count of acknowledges.

// File: rtl/flashHostPkg.sv
package flashHostPkg;

  typedef enum logic [3:0] {
    PH_IDLE,
    PH_SETUP,
    PH_AVD,
    PH_HOLD,
    PH_TURN,
    PH_ACCESS,
    PH_RECOVER,
    PH_DONE,
    PH_DEVRST
  } phase_t;

  // Strobes from the sequencer to the datapath and pin stage.
  typedef struct packed {
    logic ceN;
    logic oeN;
    logic weN;
    logic avdN;
    logic devRstN;
    logic drvAddr;
    logic drvData;
    logic latchReq;
    logic captureRd;
  } strobe_t;

  localparam strobe_t STROBE_IDLE = '{
    ceN: 1'b1, oeN: 1'b1, weN: 1'b1, avdN: 1'b1, devRstN: 1'b1,
    drvAddr: 1'b0, drvData: 1'b0, latchReq: 1'b0, captureRd: 1'b0
  };

endpackage

// File: rtl/flashHostCtrl.sv
module flashHostCtrl
  import flashHostPkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic             devRstReq,
  input  logic [CNT_W-1:0] cfgSetup,
  input  logic [CNT_W-1:0] cfgAvdWidth,
  input  logic [CNT_W-1:0] cfgAccess,
  input  logic [CNT_W-1:0] cfgRecover,
  input  logic [CNT_W-1:0] cfgRstWidth,
  output strobe_t          strobes,
  output logic             reqAck
);

  localparam logic [CNT_W-1:0] CNT_ZERO = '0;

  phase_t           phase, phaseNext;
  logic [CNT_W-1:0] cnt, cntNext;
  logic             isWrite, isWriteNext;
  logic             cntDone;

  // Remaining-cycle load value: a count of zero behaves as one (R10).
  function automatic logic [CNT_W-1:0] loadOf(input logic [CNT_W-1:0] v);
    return (v == CNT_ZERO) ? CNT_ZERO : v - 1'b1;
  endfunction

  assign cntDone = (cnt == CNT_ZERO);

  always_comb begin
    phaseNext   = phase;
    cntNext     = cntDone ? cnt : cnt - 1'b1;
    isWriteNext = isWrite;
    unique case (phase)
      PH_IDLE: begin
        if (devRstReq) begin
          phaseNext = PH_DEVRST;
          cntNext   = loadOf(cfgRstWidth);
        end else if (reqValid) begin
          phaseNext   = PH_SETUP;
          cntNext     = loadOf(cfgSetup);
          isWriteNext = reqWrite;
        end
      end
      PH_SETUP: if (cntDone) begin
        phaseNext = PH_AVD;
        cntNext   = loadOf(cfgAvdWidth);
      end
      PH_AVD: if (cntDone) phaseNext = PH_HOLD;
      PH_HOLD: begin
        if (isWrite) begin
          phaseNext = PH_ACCESS;
          cntNext   = loadOf(cfgAccess);
        end else begin
          phaseNext = PH_TURN;
        end
      end
      PH_TURN: begin
        phaseNext = PH_ACCESS;
        cntNext   = loadOf(cfgAccess);
      end
      PH_ACCESS: if (cntDone) begin
        phaseNext = PH_RECOVER;
        cntNext   = loadOf(cfgRecover);
      end
      PH_RECOVER: if (cntDone) phaseNext = PH_DONE;
      PH_DONE:    phaseNext = PH_IDLE;
      PH_DEVRST:  if (cntDone) phaseNext = PH_IDLE;
      default:    phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      cnt     <= CNT_ZERO;
      isWrite <= 1'b0;
    end else begin
      phase   <= phaseNext;
      cnt     <= cntNext;
      isWrite <= isWriteNext;
    end
  end

  // Strobe decode from the registered phase.
  always_comb begin
    strobes = STROBE_IDLE;
    unique case (phase)
      PH_IDLE: strobes.latchReq = !devRstReq && reqValid;
      PH_SETUP: begin
        strobes.ceN     = 1'b0;
        strobes.drvAddr = 1'b1;
      end
      PH_AVD: begin
        strobes.ceN     = 1'b0;
        strobes.avdN    = 1'b0;
        strobes.drvAddr = 1'b1;
      end
      PH_HOLD: begin
        strobes.ceN     = 1'b0;
        strobes.drvAddr = 1'b1;
      end
      PH_TURN: strobes.ceN = 1'b0;
      PH_ACCESS: begin
        strobes.ceN = 1'b0;
        if (isWrite) begin
          strobes.weN     = 1'b0;
          strobes.drvData = 1'b1;
        end else begin
          strobes.oeN       = 1'b0;
          strobes.captureRd = cntDone;
        end
      end
      PH_DEVRST: strobes.devRstN = 1'b0;
      default: ;
    endcase
  end

  assign reqAck = (phase == PH_DONE);

endmodule

// File: rtl/flashHostData.sv
module flashHostData
  import flashHostPkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic [DATA_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] fAdqIn,
  output logic [DATA_W-1:0] rspData,
  output logic [DATA_W-1:0] fAdqOut,
  output logic              fAdqOe,
  output logic              fCeN,
  output logic              fOeN,
  output logic              fWeN,
  output logic              fAvdN,
  output logic              fRstN
);

  logic [DATA_W-1:0] addrReg, dataReg, rdReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0;
      dataReg <= '0;
      rdReg   <= '0;
    end else begin
      if (strobes.latchReq) begin
        addrReg <= reqAddr;
        dataReg <= reqWdata;
      end
      if (strobes.captureRd) rdReg <= fAdqIn;
    end
  end

  assign fAdqOe  = strobes.drvAddr | strobes.drvData;
  assign fAdqOut = strobes.drvData ? dataReg : (strobes.drvAddr ? addrReg : '0);
  assign rspData = rdReg;
  assign fCeN    = strobes.ceN;
  assign fOeN    = strobes.oeN;
  assign fWeN    = strobes.weN;
  assign fAvdN   = strobes.avdN;
  assign fRstN   = strobes.devRstN;

endmodule

// File: rtl/muxFlashHost.sv
module muxFlashHost
  import flashHostPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [DATA_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              devRstReq,
  input  logic [CNT_W-1:0]  cfgSetup,
  input  logic [CNT_W-1:0]  cfgAvdWidth,
  input  logic [CNT_W-1:0]  cfgAccess,
  input  logic [CNT_W-1:0]  cfgRecover,
  input  logic [CNT_W-1:0]  cfgRstWidth,
  output logic              reqAck,
  output logic [DATA_W-1:0] rspData,
  output logic [DATA_W-1:0] fAdqOut,
  output logic              fAdqOe,
  input  logic [DATA_W-1:0] fAdqIn,
  output logic              fCeN,
  output logic              fOeN,
  output logic              fWeN,
  output logic              fAvdN,
  output logic              fRstN
);

  strobe_t strobes;

  flashHostCtrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .reqWrite    (reqWrite),
    .devRstReq   (devRstReq),
    .cfgSetup    (cfgSetup),
    .cfgAvdWidth (cfgAvdWidth),
    .cfgAccess   (cfgAccess),
    .cfgRecover  (cfgRecover),
    .cfgRstWidth (cfgRstWidth),
    .strobes     (strobes),
    .reqAck      (reqAck)
  );

  flashHostData #(.DATA_W(DATA_W)) u_data (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .fAdqIn   (fAdqIn),
    .rspData  (rspData),
    .fAdqOut  (fAdqOut),
    .fAdqOe   (fAdqOe),
    .fCeN     (fCeN),
    .fOeN     (fOeN),
    .fWeN     (fWeN),
    .fAvdN    (fAvdN),
    .fRstN    (fRstN)
  );

endmodule

// File: rtl/flashHostChecker.sv
module flashHostChecker #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqAck,
  input logic              fCeN,
  input logic              fOeN,
  input logic              fWeN,
  input logic              fAvdN,
  input logic              fRstN,
  input logic              fAdqOe,
  input logic [DATA_W-1:0] fAdqOut
);

  a_r11_oe_bus_free: assert property (@(posedge clk) disable iff (!rstN)
    !fOeN |-> (!fAdqOe && fAvdN));

  a_r2_addr_held_at_latch: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fAvdN) |-> (fAdqOe && !fCeN && $stable(fAdqOut)));

  a_r3_oe_after_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $fell(fOeN) |-> ($past(fAvdN) && !$past(fAdqOe)));

  a_r5_we_oe_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(!fWeN && !fOeN));

  a_r7_standby_quiet: assert property (@(posedge clk) disable iff (!rstN)
    fCeN |-> (fOeN && fWeN && fAvdN));

  a_r8_reset_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !fRstN |-> (fCeN && !fAdqOe && fOeN && fWeN && fAvdN && !reqAck));

  a_r6_ack_single: assert property (@(posedge clk) disable iff (!rstN)
    reqAck |=> !reqAck);

  a_r6_ack_deselected: assert property (@(posedge clk) disable iff (!rstN)
    reqAck |-> (fCeN && !fAdqOe));

endmodule

bind muxFlashHost flashHostChecker #(.DATA_W(DATA_W)) u_check (
  .clk     (clk),
  .rstN    (rstN),
  .reqAck  (reqAck),
  .fCeN    (fCeN),
  .fOeN    (fOeN),
  .fWeN    (fWeN),
  .fAvdN   (fAvdN),
  .fRstN   (fRstN),
  .fAdqOe  (fAdqOe),
  .fAdqOut (fAdqOut)
);

// File: tb/test_muxFlashHost.sv
module test_muxFlashHost;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rstN;
  logic          reqValid, reqWrite, devRstReq;
  logic [DW-1:0] reqAddr, reqWdata, fAdqIn;
  logic [CW-1:0] cfgSetup, cfgAvdWidth, cfgAccess, cfgRecover, cfgRstWidth;
  logic          reqAck, fAdqOe, fCeN, fOeN, fWeN, fAvdN, fRstN;
  logic [DW-1:0] rspData, fAdqOut;

  always #(CLK_PERIOD/2) clk = ~clk;

  muxFlashHost #(.DATA_W(DW), .CNT_W(CW)) i_muxFlashHost (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .devRstReq(devRstReq),
    .cfgSetup(cfgSetup), .cfgAvdWidth(cfgAvdWidth), .cfgAccess(cfgAccess),
    .cfgRecover(cfgRecover), .cfgRstWidth(cfgRstWidth),
    .reqAck(reqAck), .rspData(rspData), .fAdqOut(fAdqOut), .fAdqOe(fAdqOe),
    .fAdqIn(fAdqIn), .fCeN(fCeN), .fOeN(fOeN), .fWeN(fWeN), .fAvdN(fAvdN),
    .fRstN(fRstN)
  );

  typedef struct {
    bit ceN, oeN, weN, avdN, rstN, drv, ack, idle, chkRsp;
    logic [DW-1:0] bus, rsp;
    string tag;
  } exp_t;

  exp_t   q[$];
  exp_t   cur;
  int     nChecks = 0, nBad = 0;
  int     expAcks = 0, seenAcks = 0;
  int     sEff, aEff, accEff, rEff, rstEff;
  string  tagOvr = "";
  bit     prevAvd = 1'b1;
  int     oeLowCnt = 0;
  logic [DW-1:0] latched = '0;
  bit     finished = 1'b0;

  function automatic logic [DW-1:0] memVal(input logic [DW-1:0] a);
    return a ^ 16'h5A3C;
  endfunction

  function automatic int eff(input logic [CW-1:0] v);
    return (v == 0) ? 1 : int'(v);
  endfunction

  function automatic exp_t idleEntry(input string tag);
    exp_t e;
    e.ceN = 1; e.oeN = 1; e.weN = 1; e.avdN = 1; e.rstN = 1;
    e.drv = 0; e.ack = 0; e.idle = 1; e.chkRsp = 0;
    e.bus = '0; e.rsp = '0; e.tag = tag;
    return e;
  endfunction

  task automatic check1(input bit ok, input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] expv);
    nChecks++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, expv, $time);
    end
  endtask

  task automatic pushReq(input bit wr, input logic [DW-1:0] addr, input logic [DW-1:0] data);
    exp_t e;
    e = idleEntry("R2"); e.idle = 0; e.ceN = 0; e.drv = 1; e.bus = addr;
    repeat (sEff) q.push_back(e);
    e.avdN = 0;
    repeat (aEff) q.push_back(e);
    e.avdN = 1;
    q.push_back(e);
    if (!wr) begin
      e.drv = 0; e.tag = "R3";
      q.push_back(e);
      e.oeN = 0;
      repeat (accEff) q.push_back(e);
    end else begin
      e.weN = 0; e.bus = data; e.tag = "R5";
      repeat (accEff) q.push_back(e);
    end
    e = idleEntry("R6"); e.idle = 0;
    repeat (rEff) q.push_back(e);
    e.ack = 1; e.chkRsp = !wr; e.rsp = memVal(addr);
    e.tag = wr ? "R6" : "R4";
    q.push_back(e);
    expAcks++;
  endtask

  task automatic pushRst();
    exp_t e;
    e = idleEntry("R8"); e.idle = 0; e.rstN = 0;
    repeat (rstEff) q.push_back(e);
  endtask

  // Model acceptance for the coming edge, advance one cycle, compare.
  task automatic step();
    string t;
    if (rstN && cur.idle) begin
      if (devRstReq) pushRst();
      else if (reqValid) pushReq(reqWrite, reqAddr, reqWdata);
    end
    @(negedge clk);
    if (!rstN) q.delete();
    cur = (q.size() > 0) ? q.pop_front() : idleEntry("R7");
    t = (tagOvr != "") ? tagOvr : cur.tag;
    check1(fCeN == cur.ceN, t, "fCeN", 32'(fCeN), 32'(cur.ceN));
    check1(fOeN == cur.oeN, t, "fOeN", 32'(fOeN), 32'(cur.oeN));
    check1(fWeN == cur.weN, t, "fWeN", 32'(fWeN), 32'(cur.weN));
    check1(fAvdN == cur.avdN, t, "fAvdN", 32'(fAvdN), 32'(cur.avdN));
    check1(fRstN == cur.rstN, t, "fRstN", 32'(fRstN), 32'(cur.rstN));
    check1(fAdqOe == cur.drv, t, "fAdqOe", 32'(fAdqOe), 32'(cur.drv));
    check1(reqAck == cur.ack, t, "reqAck", 32'(reqAck), 32'(cur.ack));
    if (cur.drv) check1(fAdqOut == cur.bus, t, "fAdqOut", 32'(fAdqOut), 32'(cur.bus));
    if (cur.chkRsp) check1(rspData == cur.rsp, t, "rspData", 32'(rspData), 32'(cur.rsp));
    if (!fOeN) check1(!fAdqOe && fAvdN, "R11", "oe while driven/strobe", 32'({fAdqOe, fAvdN}), 32'h1);
    if (reqAck) seenAcks++;
    // Device model: latch address on strobe rise, return data after access time.
    if (!prevAvd && fAvdN && fAdqOe) latched = fAdqOut;
    prevAvd  = fAvdN;
    oeLowCnt = fOeN ? 0 : oeLowCnt + 1;
    fAdqIn   = (!fOeN && oeLowCnt >= accEff) ? memVal(latched) : 16'hBAD0;
  endtask

  task automatic setCfg(input int s, input int a, input int acc, input int r, input int rs);
    cfgSetup = CW'(s); cfgAvdWidth = CW'(a); cfgAccess = CW'(acc);
    cfgRecover = CW'(r); cfgRstWidth = CW'(rs);
    sEff = eff(cfgSetup); aEff = eff(cfgAvdWidth); accEff = eff(cfgAccess);
    rEff = eff(cfgRecover); rstEff = eff(cfgRstWidth);
  endtask

  task automatic waitAck();
    for (int i = 0; i < 300; i++) begin
      step();
      if (cur.ack) break;
    end
  endtask

  task automatic doReq(input bit wr, input logic [DW-1:0] addr, input logic [DW-1:0] data);
    reqValid = 1; reqWrite = wr; reqAddr = addr; reqWdata = data;
    waitAck();
    reqValid = 0;
    step();
  endtask

  initial begin
    rstN = 0; reqValid = 0; reqWrite = 0; devRstReq = 0;
    reqAddr = '0; reqWdata = '0; fAdqIn = 16'hBAD0;
    setCfg(1, 1, 1, 1, 1);
    cur = idleEntry("R1");
    tagOvr = "R1";
    repeat (3) step();
    rstN = 1;
    step();
    tagOvr = "";
    // R2 R3 R4 R6: minimal timing read
    doReq(0, 16'h1234, 16'h0);
    // R5: longer timing write, then R3 R4 read
    setCfg(2, 3, 4, 2, 1);
    doReq(1, 16'h0F0F, 16'hA55A);
    doReq(0, 16'h00FF, 16'h0);
    // R10: zero counts behave as one
    setCfg(0, 0, 0, 0, 0);
    tagOvr = "R10";
    doReq(0, 16'h7777, 16'h0);
    doReq(1, 16'h1111, 16'h2222);
    tagOvr = "";
    // R8: device reset pulse
    setCfg(1, 2, 2, 1, 3);
    devRstReq = 1;
    step();
    devRstReq = 0;
    repeat (5) step();
    // R8 priority over a simultaneous request, R9 request waits for it
    setCfg(1, 1, 2, 1, 2);
    reqValid = 1; reqWrite = 0; reqAddr = 16'h4321; devRstReq = 1;
    step();
    devRstReq = 0;
    waitAck();
    reqValid = 0;
    step();
    // R9: reset request during a cycle is ignored; held request runs back to back
    setCfg(2, 2, 3, 2, 2);
    reqValid = 1; reqWrite = 0; reqAddr = 16'hAAAA;
    repeat (3) step();
    devRstReq = 1;
    step();
    devRstReq = 0;
    waitAck();
    reqAddr = 16'hBBBB;
    waitAck();
    reqValid = 0;
    repeat (4) step();
    check1(seenAcks == expAcks, "R9", "acknowledge count", 32'(seenAcks), 32'(expAcks));
    finished = 1;
    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nBad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  end

endmodule